// File: doc/BRIEF.md
# Seven-Pin GPIO Bank with Edge/Level Status and Interrupt

This block serves a bank of seven general-purpose pins through a small byte-wide register port. Each pin's direction comes from the `pin_dir` input vector. A pin set as an input gets one status bit, and that bit works in one of two ways. In level mode it shows the synchronized pin value as it is now. In edge mode it latches a rising transition and holds it until the host reads the status register. A pin set as an output uses the same status bit position to store the level it drives out.

A mask register decides which inputs may raise the combined `irq` output. A separate pending register gives the unmasked input conditions. Reading the pending register clears nothing. Register reads are combinational, so `reg_rdata` reflects `reg_addr` during the same cycle. A read has side effects only in the cycle where `reg_rd` is high. Writes take effect at the next rising clock edge.

Top module: `gpio_trig_bank`

## Requirements
- R1: After reset, the trigger register reads 0x00, the mask register reads 0x7F (all pins masked), every edge latch and output level is 0, and `irq` is 0.
- R2: The register addresses are 0x2A (pending, read only), 0x2D (mask, 1 = masked), 0x2E (trigger select, 1 = edge, 0 = level) and 0x2F (status / output level). Bit n of each register belongs to pin n, bit 7 always reads 0, and any other address reads 0x00.
- R3: For an input pin in level mode, the status bit equals the pin value as sampled through a two-stage synchronizer. A change at the pin shows in the status bit after two rising clock edges, and the bit is never held.
- R4: For an input pin in edge mode, a rising transition of the synchronized value sets the status bit. The bit stays set, even after the pin goes low, until a status read or a reset.
- R5: A read of 0x2F returns the value from before the clear, then clears the status bits of edge-mode input pins. If a new rising transition arrives in the same cycle as the clearing read, that bit stays set.
- R6: The mask register has no effect on how status bits are set or cleared.
- R7: Reading 0x2A returns status AND NOT mask over the input pins, and clears no status bit.
- R8: For a pin set as output, writing 0x2F drives `pin_out` to the written bit, and a read of 0x2F returns that level. Write bits that fall on input pins are ignored.
- R9: `irq` is high exactly when some input pin has its status bit set and its mask bit at 0.
- R10: An edge latch is kept only while its pin is an edge-mode input. Switching the pin to level mode or to output drops the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_dir | input | 7 | Per-pin direction, 1 = output |
| pin_in | input | 7 | Asynchronous pin input levels |
| pin_out | output | 7 | Driven output levels |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (enables read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that `irq` needs an unmasked input and that a status read leaves only freshly detected edges. They also check that a pending read drops no latch, that a detected edge is latched on the next edge, that output levels move only on status writes to output pins, and that the reserved bit stays zero. The bench's scenarios show what the assertions do not cover. They cover the two-edge synchronizer latency of a level input, an edge that survives because it lands in the same cycle as the clearing read, and a latch dropped when a pin leaves edge mode. They also show that input pins ignore written data, compared against a cycle-accurate reference model under random traffic.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] ADR_PEND = 8'h2A;
  localparam logic [AW-1:0] ADR_MASK = 8'h2D;
  localparam logic [AW-1:0] ADR_TRIG = 8'h2E;
  localparam logic [AW-1:0] ADR_STAT = 8'h2F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_TRIG,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
    case (a)
      ADR_PEND: decode_addr = SEL_PEND;
      ADR_MASK: decode_addr = SEL_MASK;
      ADR_TRIG: decode_addr = SEL_TRIG;
      ADR_STAT: decode_addr = SEL_STAT;
      default:  decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic meta_q, stab_q, prev_q;
    logic meta_d, stab_d, prev_d;

    always_comb begin
      meta_d = pin_in[i];
      stab_d = meta_q;
      prev_d = stab_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        stab_q <= stab_d;
        prev_q <= prev_d;
      end
    end

    assign sync_o[i] = stab_q;
    assign rise_o[i] = stab_q & ~prev_q;
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic is_out,
  input  logic edge_mode,
  input  logic sync_v,
  input  logic rise,
  input  logic clr_rd,
  input  logic wr_stat,
  input  logic wr_bit,
  output logic edge_o,
  output logic out_o,
  output logic view_o
);
  logic edge_q, edge_d;
  logic out_q, out_d, out_en;

  always_comb begin
    if (edge_mode && !is_out) begin
      edge_d = rise | (edge_q & ~clr_rd);
    end else begin
      edge_d = 1'b0;
    end
    out_en = wr_stat & is_out;
    out_d  = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      edge_q <= edge_d;
      if (out_en) begin
        out_q <= out_d;
      end
    end
  end

  always_comb begin
    if (is_out) begin
      view_o = out_q;
    end else if (edge_mode) begin
      view_o = edge_q;
    end else begin
      view_o = sync_v;
    end
  end

  assign edge_o = edge_q;
  assign out_o  = out_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_trig_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  input  logic [N-1:0]  view,
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  trig_q,
  output logic [N-1:0]  mask_q,
  output logic          stat_wr,
  output logic          stat_rd,
  output logic [DW-1:0] reg_rdata
);
  localparam int unsigned PADW = DW - N;

  reg_sel_e     sel;
  logic         trig_en, mask_en;
  logic [N-1:0] trig_d, mask_d;
  logic [N-1:0] rd_vec;

  always_comb begin
    sel     = decode_addr(reg_addr);
    trig_en = reg_wr && (sel == SEL_TRIG);
    mask_en = reg_wr && (sel == SEL_MASK);
    stat_wr = reg_wr && (sel == SEL_STAT);
    stat_rd = reg_rd && (sel == SEL_STAT);
    trig_d  = reg_wdata[N-1:0];
    mask_d  = reg_wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      mask_q <= '1;
    end else begin
      if (trig_en) begin
        trig_q <= trig_d;
      end
      if (mask_en) begin
        mask_q <= mask_d;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_vec = pend;
      SEL_MASK: rd_vec = mask_q;
      SEL_TRIG: rd_vec = trig_q;
      SEL_STAT: rd_vec = view;
      default:  rd_vec = '0;
    endcase
    reg_rdata = {{PADW{1'b0}}, rd_vec};
  end
endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
  import gpio_trig_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_dir,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic         rst_meta_q, rst_ns;
  logic [N-1:0] sync_v, rise_v;
  logic [N-1:0] trig_q, mask_q;
  logic [N-1:0] edge_q, out_q, view, pend;
  logic         stat_wr, stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  gpio_in_sync #(.N(N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ns),
    .pin_in (pin_in),
    .sync_o (sync_v),
    .rise_o (rise_v)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    gpio_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_ns),
      .is_out    (pin_dir[i]),
      .edge_mode (trig_q[i]),
      .sync_v    (sync_v[i]),
      .rise      (rise_v[i]),
      .clr_rd    (stat_rd),
      .wr_stat   (stat_wr),
      .wr_bit    (reg_wdata[i]),
      .edge_o    (edge_q[i]),
      .out_o     (out_q[i]),
      .view_o    (view[i])
    );
  end

  assign pend    = view & ~pin_dir & ~mask_q;
  assign irq     = |pend;
  assign pin_out = out_q;

  gpio_cfg_regs #(.N(N)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .view      (view),
    .pend      (pend),
    .trig_q    (trig_q),
    .mask_q    (mask_q),
    .stat_wr   (stat_wr),
    .stat_rd   (stat_rd),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/gpio_trig_bank_chk.sv
module gpio_trig_bank_chk
  import gpio_trig_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pin_dir,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [DW-1:0] reg_rdata,
  input logic          irq,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  trig_q,
  input logic [N-1:0]  edge_q,
  input logic [N-1:0]  out_q,
  input logic [N-1:0]  rise_v
);
  // R9: an interrupt needs at least one unmasked input pin
  a_r9_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((~mask_q & ~pin_dir) != '0));

  // R5: after a status read only edges detected in that cycle remain latched
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_STAT) |=> ((edge_q & ~$past(rise_v)) == '0));

  // R7: a pending-register read drops no latch of a still edge-mode input
  a_r7_pend_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_PEND && !reg_wr) |=>
      (($past(edge_q) & ~edge_q & ~pin_dir & trig_q) == '0));

  // R4: a detected edge on an edge-mode input is latched at the next edge
  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_v & trig_q & ~pin_dir) != '0) |=>
      ((edge_q & $past(rise_v & trig_q & ~pin_dir)) == $past(rise_v & trig_q & ~pin_dir)));

  // R8: output levels change only on a status write, and only on output pins
  a_r8_out_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADR_STAT) |=> $stable(out_q));

  a_r8_input_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_STAT) |=> (((out_q ^ $past(out_q)) & ~$past(pin_dir)) == '0));

  // R2: reserved top bit reads zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1] == 1'b0);
endmodule

bind gpio_trig_bank gpio_trig_bank_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .pin_dir   (pin_dir),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .mask_q    (mask_q),
  .trig_q    (trig_q),
  .edge_q    (edge_q),
  .out_q     (out_q),
  .rise_v    (rise_v)
);

// File: tb/tb_gpio_trig_bank.sv
module tb_gpio_trig_bank;
  logic       clk;
  logic       rst_n;
  logic [6:0] pin_dir, pin_in, pin_out;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, irq;

  int vectors = 0;
  int fails   = 0;
  string phase = "R1 reset";

  // reference model state
  bit [6:0] m_s1, m_s2, m_s3, m_edge, m_out, m_trig, m_mask;
  bit       m_rs1, m_rs2;

  gpio_trig_bank dut (
    .clk(clk), .rst_n(rst_n), .pin_dir(pin_dir), .pin_in(pin_in),
    .pin_out(pin_out), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_s3 = '0; m_edge = '0; m_out = '0;
    m_trig = '0; m_mask = 7'h7F;
  endtask

  initial begin
    model_reset();
    m_rs1 = 1'b0; m_rs2 = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 1'b0; m_rs2 = 1'b0;
      model_reset();
    end else begin
      bit old_rs2;
      old_rs2 = m_rs2;
      m_rs2 = m_rs1;
      m_rs1 = 1'b1;
      if (!old_rs2) begin
        model_reset();
      end else begin
        bit [6:0] rise, nedge;
        bit       clr;
        rise = m_s2 & ~m_s3;
        clr  = reg_rd && reg_addr == 8'h2F;
        for (int i = 0; i < 7; i++) begin
          if (!pin_dir[i] && m_trig[i]) nedge[i] = rise[i] | (m_edge[i] & ~clr);
          else nedge[i] = 1'b0;
        end
        if (reg_wr && reg_addr == 8'h2F) m_out = (m_out & ~pin_dir) | (reg_wdata[6:0] & pin_dir);
        if (reg_wr && reg_addr == 8'h2E) m_trig = reg_wdata[6:0];
        if (reg_wr && reg_addr == 8'h2D) m_mask = reg_wdata[6:0];
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        m_edge = nedge;
      end
    end
  end

  function automatic bit [6:0] exp_view();
    bit [6:0] v;
    for (int i = 0; i < 7; i++)
      v[i] = pin_dir[i] ? m_out[i] : (m_trig[i] ? m_edge[i] : m_s2[i]);
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    #5;
    begin
      bit [6:0] v, p;
      bit [7:0] er;
      v = exp_view();
      p = v & ~pin_dir & ~m_mask;
      case (reg_addr)
        8'h2A: er = {1'b0, p};
        8'h2D: er = {1'b0, m_mask};
        8'h2E: er = {1'b0, m_trig};
        8'h2F: er = {1'b0, v};
        default: er = 8'h00;
      endcase
      chk(phase, "model rdata", reg_rdata, er);
      chk(phase, "model irq R9", irq, |p);
      chk(phase, "model pin_out R8", pin_out, m_out);
    end
  end

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input bit [7:0] a, input bit [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd_chk(input bit [7:0] a, input int exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    #5;
    chk(tag, "read", reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 8'h00;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_dir = '0; pin_in = '0; reg_addr = '0;
    reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    phase = "R1 reset";
    rd_chk(8'h2E, 8'h00, "R1 trig");
    rd_chk(8'h2D, 8'h7F, "R1 mask");
    rd_chk(8'h2F, 8'h00, "R1 status");
    #5; chk("R1", "irq", irq, 0); chk("R1", "pin_out", pin_out, 0);
    idle(1);

    phase = "R2 map";
    wr_reg(8'h2E, 8'hFF);
    rd_chk(8'h2E, 8'h7F, "R2 reserved bit");
    rd_chk(8'h30, 8'h00, "R2 unmapped");
    wr_reg(8'h2E, 8'h00);

    phase = "R3 level";
    pin_in = 7'h05; idle(3);
    rd_chk(8'h2F, 8'h05, "R3 level high");
    pin_in = 7'h00; idle(3);
    rd_chk(8'h2F, 8'h00, "R3 level low");

    phase = "R4 edge";
    wr_reg(8'h2E, 8'h0F);
    pin_in = 7'h02; idle(3); pin_in = 7'h00; idle(3);
    rd_chk(8'h2F, 8'h02, "R4 latched");
    rd_chk(8'h2F, 8'h00, "R5 cleared");

    phase = "R5 same cycle";
    pin_in = 7'h01; idle(2);
    rd_chk(8'h2F, 8'h00, "R5 pre-clear value");
    rd_chk(8'h2F, 8'h01, "R5 edge kept");
    rd_chk(8'h2F, 8'h00, "R5 then cleared");
    pin_in = 7'h00; idle(3);

    phase = "R6 R7 R9 mask";
    pin_in = 7'h08; idle(3);
    #5; chk("R9", "irq masked", irq, 0); idle(1);
    rd_chk(8'h2A, 8'h00, "R7 pend masked");
    wr_reg(8'h2D, 8'h77);
    #5; chk("R9", "irq unmasked", irq, 1); idle(1);
    rd_chk(8'h2A, 8'h08, "R7 pend");
    rd_chk(8'h2A, 8'h08, "R7 pend not cleared");
    rd_chk(8'h2F, 8'h08, "R6 status");
    #5; chk("R9", "irq after clear", irq, 0); idle(1);
    rd_chk(8'h2F, 8'h00, "R6 cleared");
    pin_in = 7'h00; idle(3);
    wr_reg(8'h2D, 8'h67);
    pin_in = 7'h10; idle(3);
    #5; chk("R9", "irq level", irq, 1); idle(1);
    rd_chk(8'h2A, 8'h10, "R7 pend level");
    pin_in = 7'h00; idle(3);
    #5; chk("R9", "irq level low", irq, 0); idle(1);

    phase = "R8 output";
    pin_dir = 7'h70;
    wr_reg(8'h2F, 8'h7F);
    #5; chk("R8", "pin_out", pin_out, 8'h70); idle(1);
    rd_chk(8'h2F, 8'h70, "R8 readback");
    pin_in = 7'h70; idle(3);
    #5; chk("R9", "output pins no irq", irq, 0); idle(1);
    wr_reg(8'h2F, 8'h0F);
    #5; chk("R8", "pin_out low", pin_out, 8'h00); idle(1);
    rd_chk(8'h2F, 8'h00, "R8 input bits ignored");
    pin_in = 7'h00; pin_dir = 7'h00; idle(3);

    phase = "R10 mode switch";
    pin_in = 7'h04; idle(3); pin_in = 7'h00; idle(3);
    wr_reg(8'h2E, 8'h00);
    rd_chk(8'h2F, 8'h00, "R10 level view");
    wr_reg(8'h2E, 8'h0F);
    rd_chk(8'h2F, 8'h00, "R10 latch dropped");

    phase = "random R3 R4 R5 R7 R8 R10";
    for (int k = 0; k < 2000; k++) begin
      int op;
      pin_in = 7'($urandom);
      if ($urandom_range(0, 15) == 0) pin_dir = 7'($urandom);
      op = $urandom_range(0, 9);
      reg_wdata = 8'($urandom);
      case (op)
        0: reg_addr = 8'h2A;
        1: reg_addr = 8'h2D;
        2: reg_addr = 8'h2E;
        3, 4, 5: reg_addr = 8'h2F;
        default: reg_addr = 8'h31;
      endcase
      reg_rd = ($urandom_range(0, 2) == 0);
      reg_wr = (!reg_rd) && ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    reg_rd = 1'b0; reg_wr = 1'b0;
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule